// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Signal Generator

This block holds the hypervisor's control word for one virtual interrupt CPU interface and turns it into a single level-sensitive maintenance interrupt. It watches a summary of the list registers: one valid bit and a 2-bit state for each entry. It also watches the two virtual group-enable bits and the strobes for virtual end-of-interrupt and deactivate writes. When the hypervisor has asked for it, the block raises the maintenance interrupt so that the hypervisor can refill, drain or adjust the list registers.

Some virtual end-of-interrupt or deactivate writes find no matching list register. A 5-bit wrapping counter inside the control word records each of these deactivations. Software can then retire more active interrupts than there are list register entries. Software reads the 64-bit control word through a combinational read port and writes it through a single-cycle write strobe. A write also loads the counter.

Top module: `virq_maint_gen`

## Requirements
- R1: Control word layout: bit 0 is the global enable. Bit 1 is the underflow enable, bit 2 the missing-entry enable and bit 3 the no-pending enable. Bits 4, 5, 6 and 7 are group enables for group 0 enabled, group 0 disabled, group 1 enabled and group 1 disabled. Bit 8 excludes virtual SGIs from counting. Bits 10 to 15 hold trap and mask settings that are stored only. Bits 31:27 hold the counter. All of these read back as written. Bits 63:32, 26:16 and 9 always read 0, and writes to them are ignored.
- R2: A synchronous active-high reset clears every control field, the counter and the maintenance interrupt.
- R3: An end-of-interrupt strobe increments the counter when all of these hold: its mode is 0, its interrupt ID is below 8192 and its list-register-found flag is 0. Any other combination leaves the counter unchanged.
- R4: A deactivate strobe increments the counter when all of these hold: its mode is 1, its interrupt ID is below 8192 and its list-register-found flag is 0. Any other combination leaves the counter unchanged.
- R5: While bit 8 is 1, a strobe that flags a virtual SGI never increments the counter.
- R6: The counter wraps modulo 32. If both strobes qualify in the same cycle, the counter advances by 2.
- R7: A software write loads bits 31:27 into the counter. The write overrides any increment in the same cycle.
- R8: With bits 0 and 1 set, the interrupt is asserted while zero or one list register entries are valid.
- R9: With bits 0 and 3 set, the interrupt is asserted while no entry has state 2'b01 (pending). The state of entry i is lr_state[2i+1:2i]. Its valid bit does not affect this test.
- R10: With bits 0 and 2 set, the interrupt is asserted while the counter is nonzero.
- R11: With bit 0 set, the interrupt is asserted when bit 4 is set and the group 0 enable is 1, or when bit 5 is set and the group 0 enable is 0. It is also asserted when bit 6 is set and the group 1 enable is 1, or when bit 7 is set and the group 1 enable is 0.
- R12: While bit 0 is 0, the interrupt stays low whatever the other bits and inputs are.
- R13: The interrupt is a registered OR of all enabled conditions. It changes on the first clock edge after the condition changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset |
| sw_wr_en | input | 1 | Software write strobe for the control word |
| sw_wr_data | input | 64 | Control word write data |
| sw_rd_data | output | 64 | Current control word including the counter |
| lr_valid | input | NUM_LR | Valid bit per list register entry |
| lr_state | input | 2*NUM_LR | 2-bit state per entry, entry i at [2i+1:2i] |
| vgrp0_en | input | 1 | Virtual group 0 signalling enable |
| vgrp1_en | input | 1 | Virtual group 1 signalling enable |
| eoi_wr | input | 1 | Virtual end-of-interrupt write strobe |
| eoi_id | input | ID_W | Interrupt ID of the end-of-interrupt write |
| eoi_mode | input | 1 | EOI mode at the end-of-interrupt write |
| eoi_lr_hit | input | 1 | A matching list register was found |
| eoi_is_sgi | input | 1 | The interrupt is a virtual SGI |
| dir_wr | input | 1 | Virtual deactivate write strobe |
| dir_id | input | ID_W | Interrupt ID of the deactivate write |
| dir_mode | input | 1 | EOI mode at the deactivate write |
| dir_lr_hit | input | 1 | A matching list register was found |
| dir_is_sgi | input | 1 | The interrupt is a virtual SGI |
| maint_irq | output | 1 | Level maintenance interrupt |

## Verification
The hardest situations to reach are at the counter's edges: wrapping past 31, two qualifying strobes in one cycle, and a software load that collides with an increment. Stepping up from reset would take dozens of strobes to reach the top of the range. The stimulus instead uses a software write to preload 30 or 31, then fires one or both strobes in the next cycle. For the collision case, the write and a qualifying strobe are applied in the same cycle. The one-cycle interrupt latency is checked by sampling just before and just after the edge that follows a change in the list register state.

// File: rtl/virq_maint_pkg.sv
package virq_maint_pkg;

    localparam int WORD_W   = 64;
    localparam int CNT_W    = 5;
    localparam int CNT_LSB  = 27;
    localparam int CNT_MSB  = CNT_LSB + CNT_W - 1;
    localparam int LPI_BASE = 8192;

    // bit positions software relies on
    localparam int B_EN      = 0;
    localparam int B_UNDER   = 1;
    localparam int B_MISSING = 2;
    localparam int B_NOPEND  = 3;
    localparam int B_G0ON    = 4;
    localparam int B_G0OFF   = 5;
    localparam int B_G1ON    = 6;
    localparam int B_G1OFF   = 7;
    localparam int B_SGIX    = 8;
    localparam int B_STORE_L = 10;
    localparam int B_STORE_H = 15;
    localparam int STORE_W   = B_STORE_H - B_STORE_L + 1;

    typedef struct packed {
        logic [STORE_W-1:0] stored;   // trap / mask settings, kept only
        logic               sgi_excl;
        logic               g1_off;
        logic               g1_on;
        logic               g0_off;
        logic               g0_on;
        logic               no_pend;
        logic               missing;
        logic               under;
        logic               en;
    } ctl_t;

    function automatic ctl_t word_to_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.stored   = w[B_STORE_H:B_STORE_L];
        c.sgi_excl = w[B_SGIX];
        c.g1_off   = w[B_G1OFF];
        c.g1_on    = w[B_G1ON];
        c.g0_off   = w[B_G0OFF];
        c.g0_on    = w[B_G0ON];
        c.no_pend  = w[B_NOPEND];
        c.missing  = w[B_MISSING];
        c.under    = w[B_UNDER];
        c.en       = w[B_EN];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctl_to_word(input ctl_t c,
                                                      input logic [CNT_W-1:0] cnt);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CNT_MSB:CNT_LSB]     = cnt;
        w[B_STORE_H:B_STORE_L] = c.stored;
        w[B_SGIX]    = c.sgi_excl;
        w[B_G1OFF]   = c.g1_off;
        w[B_G1ON]    = c.g1_on;
        w[B_G0OFF]   = c.g0_off;
        w[B_G0ON]    = c.g0_on;
        w[B_NOPEND]  = c.no_pend;
        w[B_MISSING] = c.missing;
        w[B_UNDER]   = c.under;
        w[B_EN]      = c.en;
        return w;
    endfunction

    // a strobe counts when its mode matches, the ID is below the LPI range,
    // no list register matched and the SGI exclusion does not apply
    function automatic logic deact_counts(input logic        strobe,
                                          input logic        mode,
                                          input logic        want_mode,
                                          input logic [31:0] id,
                                          input logic        hit,
                                          input logic        is_sgi,
                                          input logic        excl);
        return strobe && (mode == want_mode) && (id < 32'(LPI_BASE))
               && !hit && !(excl && is_sgi);
    endfunction

endpackage

// File: rtl/virq_ctl_reg.sv
module virq_ctl_reg
    import virq_maint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr_en,
    input  logic [WORD_W-1:0] sw_wr_data,
    output ctl_t              ctl
);
    always_ff @(posedge clk) begin
        if (rst)           ctl <= '0;
        else if (sw_wr_en) ctl <= word_to_ctl(sw_wr_data);
    end

    assert_rst_clear_R2: assert property (@(posedge clk) rst |=> ctl == '0);
endmodule

// File: rtl/virq_deact_counter.sv
module virq_deact_counter
    import virq_maint_pkg::*;
#(
    parameter int ID_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sgi_excl,
    input  logic             sw_wr_en,
    input  logic [CNT_W-1:0] sw_cnt,
    input  logic             eoi_wr,
    input  logic [ID_W-1:0]  eoi_id,
    input  logic             eoi_mode,
    input  logic             eoi_lr_hit,
    input  logic             eoi_is_sgi,
    input  logic             dir_wr,
    input  logic [ID_W-1:0]  dir_id,
    input  logic             dir_mode,
    input  logic             dir_lr_hit,
    input  logic             dir_is_sgi,
    output logic [CNT_W-1:0] cnt
);
    logic eoi_q, dir_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        eoi_q = deact_counts(eoi_wr, eoi_mode, 1'b0, 32'(eoi_id), eoi_lr_hit,
                             eoi_is_sgi, sgi_excl);
        dir_q = deact_counts(dir_wr, dir_mode, 1'b1, 32'(dir_id), dir_lr_hit,
                             dir_is_sgi, sgi_excl);
        step  = CNT_W'(eoi_q) + CNT_W'(dir_q);
    end

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (sw_wr_en) cnt <= sw_cnt;
        else               cnt <= cnt + step;   // wraps modulo 2**CNT_W
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && !eoi_q && !dir_q) |=> cnt == $past(cnt));
    assert_wrap_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr_en && (eoi_q != dir_q)) |=> cnt == CNT_W'($past(cnt) + 1'b1));
    assert_sgi_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (sgi_excl && eoi_wr && eoi_is_sgi && !dir_wr && !sw_wr_en)
        |=> cnt == $past(cnt));
    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> cnt == $past(sw_cnt));
endmodule

// File: rtl/virq_lr_summary.sv
module virq_lr_summary #(
    parameter int NUM_LR = 4
) (
    input  logic [NUM_LR-1:0]   lr_valid,
    input  logic [2*NUM_LR-1:0] lr_state,
    output logic                few_valid,
    output logic                none_pending
);
    localparam int VC_W = $clog2(NUM_LR + 1);

    logic [NUM_LR-1:0] pend;
    logic [VC_W-1:0]   vcount;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
        assign pend[i] = (lr_state[2*i+1:2*i] == 2'b01);
    end

    always_comb begin
        vcount = '0;
        for (int i = 0; i < NUM_LR; i++) vcount = vcount + VC_W'(lr_valid[i]);
        few_valid    = (vcount <= VC_W'(1));
        none_pending = ~|pend;
    end
endmodule

// File: rtl/virq_maint_gen.sv
module virq_maint_gen
    import virq_maint_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ID_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_wr_en,
    input  logic [WORD_W-1:0]   sw_wr_data,
    output logic [WORD_W-1:0]   sw_rd_data,
    input  logic [NUM_LR-1:0]   lr_valid,
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic                vgrp0_en,
    input  logic                vgrp1_en,
    input  logic                eoi_wr,
    input  logic [ID_W-1:0]     eoi_id,
    input  logic                eoi_mode,
    input  logic                eoi_lr_hit,
    input  logic                eoi_is_sgi,
    input  logic                dir_wr,
    input  logic [ID_W-1:0]     dir_id,
    input  logic                dir_mode,
    input  logic                dir_lr_hit,
    input  logic                dir_is_sgi,
    output logic                maint_irq
);
    ctl_t             ctl;
    logic [CNT_W-1:0] cnt;
    logic             few_valid, none_pending;
    logic [6:0]       cond;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{sw_wr_data[WORD_W-1:CNT_MSB+1],
                              sw_wr_data[CNT_LSB-1:B_STORE_H+1],
                              sw_wr_data[B_STORE_L-1]};

    virq_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .ctl(ctl)
    );

    virq_deact_counter #(.ID_W(ID_W)) u_cnt (
        .clk(clk), .rst(rst), .sgi_excl(ctl.sgi_excl),
        .sw_wr_en(sw_wr_en), .sw_cnt(sw_wr_data[CNT_MSB:CNT_LSB]),
        .eoi_wr(eoi_wr), .eoi_id(eoi_id), .eoi_mode(eoi_mode),
        .eoi_lr_hit(eoi_lr_hit), .eoi_is_sgi(eoi_is_sgi),
        .dir_wr(dir_wr), .dir_id(dir_id), .dir_mode(dir_mode),
        .dir_lr_hit(dir_lr_hit), .dir_is_sgi(dir_is_sgi),
        .cnt(cnt)
    );

    virq_lr_summary #(.NUM_LR(NUM_LR)) u_lrs (
        .lr_valid(lr_valid), .lr_state(lr_state),
        .few_valid(few_valid), .none_pending(none_pending)
    );

    assign sw_rd_data = ctl_to_word(ctl, cnt);

    always_comb begin
        cond[0] = ctl.under   && few_valid;
        cond[1] = ctl.no_pend && none_pending;
        cond[2] = ctl.missing && (cnt != '0);
        cond[3] = ctl.g0_on   &&  vgrp0_en;
        cond[4] = ctl.g0_off  && !vgrp0_en;
        cond[5] = ctl.g1_on   &&  vgrp1_en;
        cond[6] = ctl.g1_off  && !vgrp1_en;
    end

    always_ff @(posedge clk) begin
        if (rst) maint_irq <= 1'b0;
        else     maint_irq <= ctl.en && (|cond);
    end

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        sw_rd_data[WORD_W-1:CNT_MSB+1] == '0 && sw_rd_data[CNT_LSB-1:B_STORE_H+1] == '0
        && sw_rd_data[B_STORE_L-1] == 1'b0);
    assert_irq_rst_R2: assert property (@(posedge clk) rst |=> !maint_irq);
    assert_under_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.under && $countones(lr_valid) <= 1) |=> maint_irq);
    assert_nopend_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.no_pend && none_pending) |=> maint_irq);
    assert_missing_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.missing && cnt != '0) |=> maint_irq);
    assert_gate_R12: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !maint_irq);
endmodule

// File: tb/tb_virq_maint_gen.sv
module tb_virq_maint_gen;
    localparam int NUM_LR = 4;
    localparam int ID_W   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sw_wr_en = 1'b0;
    logic [63:0]       sw_wr_data = '0;
    logic [63:0]       sw_rd_data;
    logic [NUM_LR-1:0] lr_valid = '0;
    logic [2*NUM_LR-1:0] lr_state = '0;
    logic              vgrp0_en = 1'b0, vgrp1_en = 1'b0;
    logic              eoi_wr = 1'b0, eoi_mode = 1'b0, eoi_lr_hit = 1'b0, eoi_is_sgi = 1'b0;
    logic              dir_wr = 1'b0, dir_mode = 1'b0, dir_lr_hit = 1'b0, dir_is_sgi = 1'b0;
    logic [ID_W-1:0]   eoi_id = '0, dir_id = '0;
    logic              maint_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    virq_maint_gen #(.NUM_LR(NUM_LR), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_data(sw_rd_data), .lr_valid(lr_valid), .lr_state(lr_state),
        .vgrp0_en(vgrp0_en), .vgrp1_en(vgrp1_en),
        .eoi_wr(eoi_wr), .eoi_id(eoi_id), .eoi_mode(eoi_mode),
        .eoi_lr_hit(eoi_lr_hit), .eoi_is_sgi(eoi_is_sgi),
        .dir_wr(dir_wr), .dir_id(dir_id), .dir_mode(dir_mode),
        .dir_lr_hit(dir_lr_hit), .dir_is_sgi(dir_is_sgi),
        .maint_irq(maint_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cw(input logic [4:0] c, input logic [15:0] f);
        return {32'h0, c, 11'h0, f};
    endfunction

    task automatic wr(input logic [63:0] d);
        @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = d;
        @(negedge clk); sw_wr_en = 1'b0; sw_wr_data = '0;
    endtask

    task automatic eoi(input logic [15:0] id, input logic md, input logic hit, input logic sgi);
        @(negedge clk); eoi_wr = 1'b1; eoi_id = id; eoi_mode = md;
        eoi_lr_hit = hit; eoi_is_sgi = sgi;
        @(negedge clk); eoi_wr = 1'b0;
    endtask

    task automatic dir(input logic [15:0] id, input logic md, input logic hit, input logic sgi);
        @(negedge clk); dir_wr = 1'b1; dir_id = id; dir_mode = md;
        dir_lr_hit = hit; dir_is_sgi = sgi;
        @(negedge clk); dir_wr = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk); @(negedge clk);
    endtask

    function automatic logic [4:0] cnt_rd();
        return sw_rd_data[31:27];
    endfunction

    task automatic t_reset();
        chk("R2 word", sw_rd_data, 64'h0);
        chk("R2 irq", 64'(maint_irq), 64'h0);
    endtask

    task automatic t_fields();
        wr('1);
        chk("R1 ones", sw_rd_data, 64'h0000_0000_F800_FDFF);
        wr(64'h0000_0000_0001_0200);
        chk("R1 rsvd only", sw_rd_data, 64'h0);
        wr(64'h0000_0000_5000_A55A);
        chk("R1 pattern", sw_rd_data, 64'h0000_0000_5000_A55A);
        wr('0);
    endtask

    task automatic t_eoi();
        eoi(16'd100, 1'b0, 1'b0, 1'b0);  chk("R3 count", 64'(cnt_rd()), 1);
        eoi(16'd100, 1'b0, 1'b1, 1'b0);  chk("R3 hit", 64'(cnt_rd()), 1);
        eoi(16'd8192, 1'b0, 1'b0, 1'b0); chk("R3 lpi", 64'(cnt_rd()), 1);
        eoi(16'd8191, 1'b0, 1'b0, 1'b0); chk("R3 top id", 64'(cnt_rd()), 2);
        eoi(16'd5, 1'b1, 1'b0, 1'b0);    chk("R3 mode1", 64'(cnt_rd()), 2);
    endtask

    task automatic t_dir();
        dir(16'd5, 1'b1, 1'b0, 1'b0);    chk("R4 count", 64'(cnt_rd()), 3);
        dir(16'd5, 1'b0, 1'b0, 1'b0);    chk("R4 mode0", 64'(cnt_rd()), 3);
        dir(16'd9000, 1'b1, 1'b0, 1'b0); chk("R4 lpi", 64'(cnt_rd()), 3);
        dir(16'd5, 1'b1, 1'b1, 1'b0);    chk("R4 hit", 64'(cnt_rd()), 3);
    endtask

    task automatic t_sgi();
        wr(cw(5'd0, 16'h0100));
        eoi(16'd3, 1'b0, 1'b0, 1'b1);    chk("R5 eoi sgi", 64'(cnt_rd()), 0);
        dir(16'd3, 1'b1, 1'b0, 1'b1);    chk("R5 dir sgi", 64'(cnt_rd()), 0);
        eoi(16'd40, 1'b0, 1'b0, 1'b0);   chk("R5 non sgi", 64'(cnt_rd()), 1);
        wr(cw(5'd0, 16'h0000));
        eoi(16'd3, 1'b0, 1'b0, 1'b1);    chk("R5 excl off", 64'(cnt_rd()), 1);
    endtask

    task automatic t_wrap();
        wr(cw(5'd30, 16'h0));
        @(negedge clk);
        eoi_wr = 1'b1; eoi_id = 16'd7; eoi_mode = 1'b0; eoi_lr_hit = 1'b0; eoi_is_sgi = 1'b0;
        dir_wr = 1'b1; dir_id = 16'd8; dir_mode = 1'b1; dir_lr_hit = 1'b0; dir_is_sgi = 1'b0;
        @(negedge clk); eoi_wr = 1'b0; dir_wr = 1'b0;
        chk("R6 double wrap", 64'(cnt_rd()), 0);
        wr(cw(5'd31, 16'h0));
        eoi(16'd1, 1'b0, 1'b0, 1'b0);    chk("R6 wrap", 64'(cnt_rd()), 0);
    endtask

    task automatic t_prio();
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = cw(5'd7, 16'h0);
        eoi_wr = 1'b1; eoi_id = 16'd9; eoi_mode = 1'b0; eoi_lr_hit = 1'b0; eoi_is_sgi = 1'b0;
        @(negedge clk); sw_wr_en = 1'b0; eoi_wr = 1'b0;
        chk("R7 load wins", 64'(cnt_rd()), 7);
    endtask

    task automatic t_under();
        lr_state = '0; lr_valid = 4'b0011;
        wr(cw(5'd0, 16'h0003)); settle();
        chk("R8 two valid", 64'(maint_irq), 0);
        lr_valid = 4'b0100; settle();
        chk("R8 one valid", 64'(maint_irq), 1);
        lr_valid = 4'b0000; settle();
        chk("R8 none valid", 64'(maint_irq), 1);
    endtask

    task automatic t_nopend();
        lr_valid = 4'b1111; lr_state = 8'b00_01_10_11;
        wr(cw(5'd0, 16'h0009)); settle();
        chk("R9 one pending", 64'(maint_irq), 0);
        lr_valid = 4'b0000; settle();
        chk("R9 pending invalid entry", 64'(maint_irq), 0);
        lr_state = 8'b11_10_00_10; settle();
        chk("R9 none pending", 64'(maint_irq), 1);
    endtask

    task automatic t_missing();
        lr_valid = 4'b1111; lr_state = 8'b01_01_01_01;
        wr(cw(5'd0, 16'h0005)); settle();
        chk("R10 zero count", 64'(maint_irq), 0);
        wr(cw(5'd3, 16'h0005)); settle();
        chk("R10 nonzero", 64'(maint_irq), 1);
    endtask

    task automatic t_groups();
        lr_valid = 4'b1111; lr_state = 8'b01_01_01_01;
        vgrp0_en = 1'b1; vgrp1_en = 1'b0;
        wr(cw(5'd0, 16'h0011)); settle(); chk("R11 g0 on", 64'(maint_irq), 1);
        wr(cw(5'd0, 16'h0021)); settle(); chk("R11 g0 off", 64'(maint_irq), 0);
        wr(cw(5'd0, 16'h0041)); settle(); chk("R11 g1 on", 64'(maint_irq), 0);
        wr(cw(5'd0, 16'h0081)); settle(); chk("R11 g1 off", 64'(maint_irq), 1);
        vgrp1_en = 1'b1; settle();        chk("R11 g1 off flip", 64'(maint_irq), 0);
    endtask

    task automatic t_gate();
        lr_valid = 4'b0000; lr_state = '0; vgrp0_en = 1'b1; vgrp1_en = 1'b0;
        wr(cw(5'd9, 16'h00FE)); settle();
        chk("R12 disabled", 64'(maint_irq), 0);
    endtask

    task automatic t_latency();
        lr_valid = 4'b1111; lr_state = 8'b01_01_01_01;
        wr(cw(5'd0, 16'h0009)); settle();
        chk("R13 before", 64'(maint_irq), 0);
        @(negedge clk); lr_state = '0;
        #1 chk("R13 pre-edge", 64'(maint_irq), 0);
        @(posedge clk); #1 chk("R13 post-edge", 64'(maint_irq), 1);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_eoi();
        t_dir();
        t_sgi();
        t_wrap();
        t_prio();
        t_under();
        t_nopend();
        t_missing();
        t_groups();
        t_gate();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule